// File: doc/BRIEF.md
# DMA Channel Event Trigger Control

This block holds the trigger settings for one DMA channel. It tells the transfer engine when to start and when to abort. A single 32-bit control word, written and read over a simple synchronous bus with per-byte write enables, holds the following settings:

- two 8-bit interrupt-number selectors, one for start and one for abort;
- three enable bits: start-IRQ, abort-IRQ and pattern-abort;
- two write-only trigger bits: force-start and force-abort.

The block watches an interrupt event bus, made of a valid strobe and an 8-bit number, and a pattern-match indication from a comparator outside the block. When a programmed condition occurs, it raises a one-cycle pulse in the cycle after the event:

- a start pulse;
- an abort pulse;
- an abort-interrupt flag set, for an abort caused by an interrupt;
- a channel-enable clear, for an abort caused by a pattern match.

No pulse is produced while the channel enable input is low. Abort requests act only while the channel reports busy. When a start and an abort coincide, the abort wins.

Top module: `dma_evt_ctrl`

## Requirements
- R1: After reset the control word reads 0x00FF_FF00: both selectors hold 255 and all low-byte control bits are 0.
- R2: A write updates only the lanes whose byte enable is set. The start selector is in bits 15:8 (lane 1). The abort selector is in bits 23:16 (lane 2). Pattern-abort enable is bit 5, start-IRQ enable is bit 4 and abort-IRQ enable is bit 3 (lane 0). Bits 31:24 and 2:0 always read 0.
- R3: Force-start (bit 7) and force-abort (bit 6) always read 0.
- R4: While start-IRQ enable is 1 and the channel enable input is high, a valid interrupt whose number equals the start selector gives startPulse high for exactly the following cycle.
- R5: A valid interrupt gives no start when start-IRQ enable is 0 or when its number differs from the start selector.
- R6: A write of 1 to bit 7 with lane 0 enabled, while the channel enable input is high, gives a start pulse in the following cycle, whatever the value of start-IRQ enable.
- R7: While abort-IRQ enable is 1 and the channel enable and busy inputs are high, a valid interrupt equal to the abort selector gives abortPulse and abortFlagSet in the following cycle. Abort conditions are ignored while busy is low.
- R8: A write of 1 to bit 6 with lane 0 enabled, while enabled and busy, gives abortPulse in the following cycle but not abortFlagSet.
- R9: With pattern-abort enable at 1, a pattern match while enabled and busy gives abortPulse and chanEnClr in the following cycle. With the enable at 0, a pattern match has no effect.
- R10: While the channel enable input is low, no output pulse is produced.
- R11: When start and abort conditions occur in the same cycle, only the abort pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Control word write strobe |
| regByteEn | input | 4 | Per-byte write enables |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read of the control word |
| irqValid | input | 1 | Interrupt event valid |
| irqNum | input | 8 | Interrupt number of the event |
| patMatch | input | 1 | Pattern match seen by the channel |
| chanEn | input | 1 | Channel enable state |
| chanBusy | input | 1 | Channel has a transfer in progress |
| startPulse | output | 1 | Start a cell transfer |
| abortPulse | output | 1 | Abort the current transfer |
| abortFlagSet | output | 1 | Set the channel abort-interrupt flag |
| chanEnClr | output | 1 | Clear the channel enable |

## Verification
The assertions check, on every cycle, several relations between the outputs and the previous cycle's inputs:

- start and abort pulses never coincide;
- the flag set and the enable clear occur only with an abort pulse;
- no pulse follows a cycle with the channel disabled;
- no abort follows a cycle without busy;
- no enable clear follows a cycle with pattern-abort enable at 0;
- an enabled matching interrupt on an idle channel is always followed by a start.

The bench scenarios cover the rest. These are the byte-lane write masking, the read-as-zero trigger bits, the difference between forced and interrupt aborts for the flag, and the selector values that a start or abort compares against after a write.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int REG_W      = 32;
  localparam int LANES      = REG_W / 8;
  localparam int IRQ_W      = 8;
  localparam int START_LSB  = 8;
  localparam int ABORT_LSB  = 16;
  localparam int BIT_FSTART = 7;
  localparam int BIT_FABORT = 6;
  localparam int BIT_PATEN  = 5;
  localparam int BIT_STEN   = 4;
  localparam int BIT_ABEN   = 3;

  typedef struct packed {
    logic startIrq;
    logic startForce;
    logic abortIrq;
    logic abortForce;
    logic patAbort;
  } evtReq_t;
endpackage

// File: rtl/dma_evt_dp.sv
module dma_evt_dp
  import dma_evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [LANES-1:0]     byteEn,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     rdData,
  input  logic                 irqValid,
  input  logic [IRQ_W-1:0]     irqNum,
  input  logic                 patMatch,
  output evtReq_t              evtReq
);
  logic [IRQ_W-1:0] selStart;
  logic [IRQ_W-1:0] selAbort;
  logic             patEn;
  logic             startEn;
  logic             abortEn;
  logic             ctlLaneWr;

  assign ctlLaneWr = wrEn && byteEn[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selStart <= '1;
      selAbort <= '1;
      patEn    <= 1'b0;
      startEn  <= 1'b0;
      abortEn  <= 1'b0;
    end else if (wrEn) begin
      if (byteEn[START_LSB/8]) selStart <= wrData[START_LSB +: IRQ_W];
      if (byteEn[ABORT_LSB/8]) selAbort <= wrData[ABORT_LSB +: IRQ_W];
      if (byteEn[0]) begin
        patEn   <= wrData[BIT_PATEN];
        startEn <= wrData[BIT_STEN];
        abortEn <= wrData[BIT_ABEN];
      end
    end
  end

  always_comb begin
    rdData                        = '0;
    rdData[START_LSB +: IRQ_W]    = selStart;
    rdData[ABORT_LSB +: IRQ_W]    = selAbort;
    rdData[BIT_PATEN]             = patEn;
    rdData[BIT_STEN]              = startEn;
    rdData[BIT_ABEN]              = abortEn;
  end

  always_comb begin
    evtReq.startIrq   = irqValid && startEn && (irqNum == selStart);
    evtReq.abortIrq   = irqValid && abortEn && (irqNum == selAbort);
    evtReq.startForce = ctlLaneWr && wrData[BIT_FSTART];
    evtReq.abortForce = ctlLaneWr && wrData[BIT_FABORT];
    evtReq.patAbort   = patEn && patMatch;
  end

  logic unusedBits;
  assign unusedBits = ^{wrData[REG_W-1:ABORT_LSB+IRQ_W], wrData[BIT_ABEN-1:0], byteEn[LANES-1]};
endmodule

// File: rtl/dma_evt_ctl.sv
module dma_evt_ctl
  import dma_evt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  evtReq_t evtReq,
  input  logic    chanEn,
  input  logic    chanBusy,
  output logic    startPulse,
  output logic    abortPulse,
  output logic    abortFlagSet,
  output logic    chanEnClr
);
  logic abortLive;
  logic abIrqHit;
  logic abForceHit;
  logic patHit;
  logic startHit;

  assign abortLive  = chanEn && chanBusy;
  assign abIrqHit   = abortLive && evtReq.abortIrq;
  assign abForceHit = abortLive && evtReq.abortForce;
  assign patHit     = abortLive && evtReq.patAbort;
  assign startHit   = chanEn && (evtReq.startIrq || evtReq.startForce);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startPulse   <= 1'b0;
      abortPulse   <= 1'b0;
      abortFlagSet <= 1'b0;
      chanEnClr    <= 1'b0;
    end else begin
      abortPulse   <= abIrqHit || abForceHit || patHit;
      startPulse   <= startHit && !(abIrqHit || abForceHit || patHit);
      abortFlagSet <= abIrqHit;
      chanEnClr    <= patHit;
    end
  end
endmodule

// File: rtl/dma_evt_ctrl.sv
module dma_evt_ctrl
  import dma_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [LANES-1:0]  regByteEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic              irqValid,
  input  logic [IRQ_W-1:0]  irqNum,
  input  logic              patMatch,
  input  logic              chanEn,
  input  logic              chanBusy,
  output logic              startPulse,
  output logic              abortPulse,
  output logic              abortFlagSet,
  output logic              chanEnClr
);
  evtReq_t evtReq;

  dma_evt_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (regWrEn),
    .byteEn   (regByteEn),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .irqValid (irqValid),
    .irqNum   (irqNum),
    .patMatch (patMatch),
    .evtReq   (evtReq)
  );

  dma_evt_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .evtReq       (evtReq),
    .chanEn       (chanEn),
    .chanBusy     (chanBusy),
    .startPulse   (startPulse),
    .abortPulse   (abortPulse),
    .abortFlagSet (abortFlagSet),
    .chanEnClr    (chanEnClr)
  );
endmodule

// File: rtl/dma_evt_ctrl_chk.sv
module dma_evt_ctrl_chk
  import dma_evt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [LANES-1:0]  regByteEn,
  input logic [REG_W-1:0]  regWrData,
  input logic [REG_W-1:0]  regRdData,
  input logic              irqValid,
  input logic [IRQ_W-1:0]  irqNum,
  input logic              patMatch,
  input logic              chanEn,
  input logic              chanBusy,
  input logic              startPulse,
  input logic              abortPulse,
  input logic              abortFlagSet,
  input logic              chanEnClr
);
  AST_START_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(startPulse && abortPulse)); // R11
  AST_FLAG_NEEDS_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    abortFlagSet |-> abortPulse); // R7
  AST_CLR_NEEDS_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    chanEnClr |-> abortPulse); // R9
  AST_PULSE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse || abortPulse) |-> $past(chanEn)); // R10
  AST_ABORT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    abortPulse |-> $past(chanBusy)); // R7
  AST_CLR_NEEDS_PATEN: assert property (@(posedge clk) disable iff (!rstN)
    chanEnClr |-> $past(regRdData[BIT_PATEN])); // R9
  AST_IRQ_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && chanEn && !chanBusy && regRdData[BIT_STEN] &&
     irqNum == regRdData[START_LSB +: IRQ_W]) |=> startPulse); // R4
endmodule

bind dma_evt_ctrl dma_evt_ctrl_chk u_chk (.*);

// File: tb/dma_evt_ctrl_bench.sv
`timescale 1ns/1ps
module dma_evt_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqValid = 1'b0;
  logic [7:0]  irqNum = '0;
  logic        patMatch = 1'b0;
  logic        chanEn = 1'b0;
  logic        chanBusy = 1'b0;
  logic        startPulse, abortPulse, abortFlagSet, chanEnClr;

  int checks = 0;
  int errors = 0;

  // bench model of the control word
  logic [7:0] mSelS = 8'hFF, mSelA = 8'hFF;
  logic       mPat = 0, mSt = 0, mAb = 0;
  logic       eStart, eAbort, eFlag, eClr;

  always #10 clk = ~clk;

  dma_evt_ctrl u_dma_evt_ctrl (.*);

  function automatic logic [31:0] modelRead();
    return {8'h00, mSelA, mSelS, 2'b00, mPat, mSt, mAb, 3'b000};
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic computeExp();
    logic fS, fA, sIrq, aIrq, aF, pt;
    fS   = regWrEn && regByteEn[0] && regWrData[7];
    fA   = regWrEn && regByteEn[0] && regWrData[6];
    sIrq = irqValid && mSt && irqNum == mSelS;
    aIrq = chanEn && chanBusy && irqValid && mAb && irqNum == mSelA;
    aF   = chanEn && chanBusy && fA;
    pt   = chanEn && chanBusy && mPat && patMatch;
    eAbort = aIrq || aF || pt;
    eStart = chanEn && (sIrq || fS) && !eAbort;
    eFlag  = aIrq;
    eClr   = pt;
  endtask

  task automatic modelWrite();
    if (regWrEn) begin
      if (regByteEn[1]) mSelS = regWrData[15:8];
      if (regByteEn[2]) mSelA = regWrData[23:16];
      if (regByteEn[0]) {mPat, mSt, mAb} = regWrData[5:3];
    end
  endtask

  // drive inputs at negedge, check outputs one cycle later
  task automatic step(input logic wr, input logic [3:0] be, input logic [31:0] d,
                      input logic iv, input logic [7:0] num, input logic pm,
                      input logic en, input logic bz, input string lbl);
    regWrEn = wr; regByteEn = be; regWrData = d;
    irqValid = iv; irqNum = num; patMatch = pm; chanEn = en; chanBusy = bz;
    computeExp();
    @(posedge clk);
    modelWrite();
    @(negedge clk);
    regWrEn = 0; irqValid = 0; patMatch = 0;
    check({31'd0, startPulse},   {31'd0, eStart}, {lbl, " R4/R5/R6/R10/R11 startPulse"});
    check({31'd0, abortPulse},   {31'd0, eAbort}, {lbl, " R7/R8/R9/R10 abortPulse"});
    check({31'd0, abortFlagSet}, {31'd0, eFlag},  {lbl, " R7/R8 abortFlagSet"});
    check({31'd0, chanEnClr},    {31'd0, eClr},   {lbl, " R9 chanEnClr"});
    check(regRdData, modelRead(), {lbl, " R2/R3 readback"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = 32'h1D5A;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(regRdData, 32'h00FF_FF00, "R1 reset value");
    check({28'd0, startPulse, abortPulse, abortFlagSet, chanEnClr}, 32'd0, "R1 reset outputs");

    // R2 R3: write all ones, reserved and trigger bits read 0
    step(1, 4'hF, 32'hFFFF_FF38, 0, 0, 0, 0, 0, "R2 full write");
    check(regRdData, 32'h00FF_FF38, "R2/R3 all-ones readback");
    // R2 byte lanes
    step(1, 4'b0010, 32'h1234_5678, 0, 0, 0, 0, 0, "R2 lane1 only");
    check(regRdData, 32'h00FF_5638, "R2 lane mask");
    step(1, 4'b0101, 32'h00A5_00C0, 0, 0, 0, 0, 0, "R3 lanes0,2 with triggers");
    check(regRdData, 32'h00A5_5600, "R3 trigger bits read zero");
    // R5: start disabled
    step(0, 0, 0, 1, 8'h56, 0, 1, 0, "R5 start disabled");
    // enable start, abort irq, pattern
    step(1, 4'b0001, 32'h0000_0038, 0, 0, 0, 0, 0, "R2 enable bits");
    step(0, 0, 0, 1, 8'h56, 0, 1, 0, "R4 irq start");
    step(0, 0, 0, 1, 8'h57, 0, 1, 0, "R5 number mismatch");
    step(0, 0, 0, 1, 8'h56, 0, 0, 0, "R10 chan disabled");
    step(0, 0, 0, 1, 8'hA5, 0, 1, 1, "R7 irq abort");
    step(0, 0, 0, 1, 8'hA5, 0, 1, 0, "R7 abort not busy");
    step(1, 4'b0001, 32'h0000_0078, 0, 0, 0, 1, 1, "R8 force abort");
    step(0, 0, 0, 0, 0, 1, 1, 1, "R9 pattern abort");
    step(0, 0, 0, 1, 8'h56, 1, 1, 1, "R11 start vs pattern");
    step(1, 4'b0001, 32'h0000_00C8, 0, 0, 0, 1, 1, "R11 force both");
    step(0, 0, 0, 0, 0, 1, 1, 1, "R9 pattern enable off");
    step(1, 4'b0001, 32'h0000_0080, 0, 0, 0, 1, 0, "R6 force start no enable");
    step(1, 4'b0001, 32'h0000_00F8, 1, 8'hA5, 1, 0, 1, "R10 all while disabled");

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] n;
      int pick = $urandom_range(0, 3);
      n = (pick == 0) ? mSelS : (pick == 1) ? mSelA : 8'($urandom);
      step(($urandom_range(0, 9) == 0), 4'($urandom), $urandom,
           1'($urandom), n, 1'($urandom), ($urandom_range(0, 4) != 0), 1'($urandom),
           "random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule